// File: doc/BRIEF.md
# Merging Store Buffer

This block sits between a write-through cache and the memory behind it. The CPU posts stores into it and moves on without waiting for memory. Each of its entries holds one block address, one word slot for every word of that block, and one valid bit per word. A store to a block that already has a younger entry folds its words into that entry instead of using a new one. The oldest entry is always on offer at the memory write port, and entries leave strictly in arrival order.

A read miss from the cache asks the buffer before it asks memory. If the newest copy of the wanted word is in the buffer, that copy is returned. If the block is buffered but none of its entries has the wanted word, the read is held back until every entry for that block has drained, so a later fill from memory cannot return stale data. A dirty block evicted from a write-back cache is posted with every word marked valid. The refill can then go ahead first, and the write to memory follows later.

Top module: `mwb_top`

## Requirements
- R1: While `rst` is high and on the cycle after it, `mem_valid` and `rd_ack` are low and `st_ready` is high.
- R2: A store accepted at a clock edge (`st_valid` and `st_ready` high) into an empty buffer appears at the memory port right after that edge, with `mem_blk` set to its block, `mem_mask` set to its word mask, and its words in `mem_line`. Word w occupies bits [w*DATA_W +: DATA_W] and mask bit w.
- R3: A store whose block matches an occupied entry other than the oldest one merges into that entry. Its masked words overwrite the entry's words, its mask is ORed into the entry's mask, and no entry is added.
- R4: A store whose block matches only the oldest entry, which is the one offered at the memory port, does not change that entry. It takes a new entry.
- R5: Entries drain oldest first, one per edge with `mem_valid` and `mem_ready` both high. While `mem_ready` is low, `mem_blk`, `mem_mask` and `mem_line` hold steady.
- R6: With all DEPTH entries occupied, `st_ready` is low unless `st_blk` matches an occupied entry other than the oldest one. In that case `st_ready` is high and the store merges.
- R7: A read (`rd_valid` held until `rd_ack`) whose word is valid in a buffered entry for `rd_blk` is acknowledged one cycle after it is presented. It returns `rd_hit` = 1 and the word from the newest entry holding that word.
- R8: A read of a block that no entry holds is acknowledged one cycle after it is presented, with `rd_hit` = 0.
- R9: A read of a buffered block whose word is valid in none of its entries is not acknowledged while any entry for that block remains. It is acknowledged with `rd_hit` = 0 on the cycle after the edge at which the last such entry drains.
- R10: A store with all mask bits set (an evicted dirty block) fills every word of its entry. It drains with `mem_mask` all ones, and every word of it can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be taken this cycle |
| st_blk | input | BLK_W | Block address of the store |
| st_mask | input | WORDS | Words of the block written by the store |
| st_line | input | WORDS*DATA_W | Store data, word w at bits [w*DATA_W +: DATA_W] |
| rd_valid | input | 1 | Read lookup request, held until acknowledged |
| rd_blk | input | BLK_W | Block address of the read |
| rd_word | input | $clog2(WORDS) | Word index within the block |
| rd_ack | output | 1 | One-cycle acknowledge of the read |
| rd_hit | output | 1 | Read found its word in the buffer (valid with rd_ack) |
| rd_data | output | DATA_W | Buffered word (valid with rd_ack and rd_hit) |
| mem_valid | output | 1 | Oldest entry is offered to memory |
| mem_ready | input | 1 | Memory takes the offered entry |
| mem_blk | output | BLK_W | Block address of the oldest entry |
| mem_mask | output | WORDS | Valid words of the oldest entry |
| mem_line | output | WORDS*DATA_W | Words of the oldest entry |

## Verification
A posted store reaches the memory port at the negative edge after the clock edge that takes it. `st_ready` depends only on the stored state and `st_blk`, so the bench probes it 1 ns after it changes the inputs. A read answers in exactly one cycle when it hits or misses, so the bench counts negative edges from the moment it presents the read and expects a count of one. For a read that must wait, the bench checks each negative edge while the entries for that block drain. It then expects the acknowledge at the negative edge after the edge that follows the final drain, because the lookup at the drain edge still sees the old entry. A drain takes effect at the edge where `mem_ready` is high, and the next entry's fields are compared at the negative edge after it.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  // Result of a read lookup against the buffered entries
  typedef enum logic [1:0] {
    LK_MISS = 2'd0,
    LK_HIT  = 2'd1,
    LK_WAIT = 2'd2
  } lookup_e;
endpackage

// File: rtl/mwb_fifo_ctl.sv
// Ring-pointer bookkeeping for the entry array: age order and occupancy.
module mwb_fifo_ctl #(
  parameter  int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [DEPTH-1:0] head_oh,
  output logic [DEPTH-1:0] occ,
  output logic             full,
  output logic             empty
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [PTR_W-1:0] age;
    assign age        = PTR_W'(g) - head;
    assign occ[g]     = CNT_W'(age) < cnt;
    assign head_oh[g] = (head == PTR_W'(g));
  end
endmodule

// File: rtl/mwb_match.sv
// Parallel block-address compare across all occupied entries.
module mwb_match #(
  parameter int DEPTH = 4,
  parameter int BLK_W = 26
) (
  input  logic [DEPTH-1:0][BLK_W-1:0] tags,
  input  logic [DEPTH-1:0]            occ,
  input  logic [BLK_W-1:0]            key,
  output logic [DEPTH-1:0]            hit
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = occ[g] && (tags[g] == key);
  end
endmodule

// File: rtl/mwb_top.sv
module mwb_top
  import mwb_pkg::*;
#(
  parameter  int DEPTH  = 4,
  parameter  int WORDS  = 4,
  parameter  int DATA_W = 32,
  parameter  int BLK_W  = 26,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [BLK_W-1:0]  st_blk,
  input  logic [WORDS-1:0]  st_mask,
  input  logic [LINE_W-1:0] st_line,
  input  logic              rd_valid,
  input  logic [BLK_W-1:0]  rd_blk,
  input  logic [WIDX_W-1:0] rd_word,
  output logic              rd_ack,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [BLK_W-1:0]  mem_blk,
  output logic [WORDS-1:0]  mem_mask,
  output logic [LINE_W-1:0] mem_line
);
  localparam int PTR_W = $clog2(DEPTH);

  // Entry storage: tags, per-word valid bits, words
  logic [DEPTH-1:0][BLK_W-1:0] tag_q;
  logic [WORDS-1:0]            wv_q  [DEPTH];
  logic [DATA_W-1:0]           dat_q [DEPTH][WORDS];

  logic [PTR_W-1:0] head, tail;
  logic [DEPTH-1:0] head_oh, occ;
  logic             full, empty, push, pop;

  mwb_fifo_ctl #(.DEPTH(DEPTH)) ctl_i (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .head(head), .tail(tail), .head_oh(head_oh), .occ(occ),
    .full(full), .empty(empty)
  );

  // Store side: merge only into a younger entry, never the one being drained
  logic [DEPTH-1:0] s_vec, s_oth;
  logic             s_oth_any;
  logic [PTR_W-1:0] s_idx, wr_idx;
  logic             st_fire;

  mwb_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) st_cmp_i (
    .tags(tag_q), .occ(occ), .key(st_blk), .hit(s_vec)
  );

  assign s_oth     = s_vec & ~head_oh;
  assign s_oth_any = |s_oth;

  always_comb begin
    s_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (s_oth[i]) s_idx = PTR_W'(i);
  end

  assign st_ready = !full || s_oth_any;
  assign st_fire  = st_valid && st_ready;
  assign push     = st_fire && !s_oth_any;
  assign wr_idx   = s_oth_any ? s_idx : tail;
  assign pop      = !empty && mem_ready;

  always_ff @(posedge clk) begin
    if (st_fire) begin
      for (int w = 0; w < WORDS; w++)
        if (st_mask[w]) dat_q[wr_idx][w] <= st_line[w*DATA_W +: DATA_W];
      if (s_oth_any) begin
        wv_q[wr_idx] <= wv_q[wr_idx] | st_mask;
      end else begin
        wv_q[wr_idx]  <= st_mask;
        tag_q[wr_idx] <= st_blk;
      end
    end
  end

  // Read side: newest copy of the word wins; partial block forces a wait
  logic [DEPTH-1:0]  r_vec, r_oth;
  logic              r_oth_any, r_hd, oth_has, hd_has;
  logic [PTR_W-1:0]  r_idx;
  lookup_e           lk;
  logic [DATA_W-1:0] lk_data;

  mwb_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) rd_cmp_i (
    .tags(tag_q), .occ(occ), .key(rd_blk), .hit(r_vec)
  );

  assign r_oth     = r_vec & ~head_oh;
  assign r_oth_any = |r_oth;
  assign r_hd      = |(r_vec & head_oh);

  always_comb begin
    r_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (r_oth[i]) r_idx = PTR_W'(i);
  end

  assign oth_has = r_oth_any && wv_q[r_idx][rd_word];
  assign hd_has  = r_hd && wv_q[head][rd_word];

  always_comb begin
    lk      = LK_MISS;
    lk_data = '0;
    if (oth_has) begin
      lk      = LK_HIT;
      lk_data = dat_q[r_idx][rd_word];
    end else if (hd_has) begin
      lk      = LK_HIT;
      lk_data = dat_q[head][rd_word];
    end else if (r_oth_any || r_hd) begin
      lk      = LK_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack  <= 1'b0;
      rd_hit  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack  <= rd_valid && !rd_ack && (lk != LK_WAIT);
      rd_hit  <= (lk == LK_HIT);
      rd_data <= lk_data;
    end
  end

  // Drain port: oldest entry is always on offer
  assign mem_valid = !empty;
  assign mem_blk   = tag_q[head];
  assign mem_mask  = wv_q[head];
  for (genvar w = 0; w < WORDS; w++) begin : g_line
    assign mem_line[w*DATA_W +: DATA_W] = dat_q[head][w];
  end
endmodule

// File: rtl/mwb_chk.sv
module mwb_chk #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int BLK_W  = 26
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    st_valid,
  input logic                    st_ready,
  input logic                    rd_valid,
  input logic                    rd_ack,
  input logic                    mem_valid,
  input logic                    mem_ready,
  input logic [BLK_W-1:0]        mem_blk,
  input logic [WORDS-1:0]        mem_mask,
  input logic [WORDS*DATA_W-1:0] mem_line
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!mem_valid && !rd_ack && st_ready));

  // R2
  post_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_ready) |=> mem_valid);

  // R5
  drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_blk) && $stable(mem_mask) && $stable(mem_line)));

  // R6
  stall_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    !st_ready |-> mem_valid);

  // R7
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> $past(rd_valid));
endmodule

bind mwb_top mwb_chk #(.WORDS(WORDS), .DATA_W(DATA_W), .BLK_W(BLK_W)) chk_i (
  .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
  .rd_valid(rd_valid), .rd_ack(rd_ack), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_blk(mem_blk), .mem_mask(mem_mask),
  .mem_line(mem_line)
);

// File: tb/mwb_top_tb_top.sv
module mwb_top_tb_top;
  localparam int DEPTH = 4, WORDS = 4, DATA_W = 32, BLK_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              st_valid = 1'b0, rd_valid = 1'b0, mem_ready = 1'b0;
  logic [BLK_W-1:0]  st_blk = '0, rd_blk = '0;
  logic [WORDS-1:0]  st_mask = '0;
  logic [127:0]      st_line = '0;
  logic [1:0]        rd_word = '0;
  logic              st_ready, rd_ack, rd_hit, mem_valid;
  logic [DATA_W-1:0] rd_data;
  logic [BLK_W-1:0]  mem_blk;
  logic [WORDS-1:0]  mem_mask;
  logic [127:0]      mem_line;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mwb_top #(.DEPTH(DEPTH), .WORDS(WORDS), .DATA_W(DATA_W), .BLK_W(BLK_W)) dut_i (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_blk(st_blk), .st_mask(st_mask), .st_line(st_line),
    .rd_valid(rd_valid), .rd_blk(rd_blk), .rd_word(rd_word),
    .rd_ack(rd_ack), .rd_hit(rd_hit), .rd_data(rd_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_blk(mem_blk),
    .mem_mask(mem_mask), .mem_line(mem_line)
  );

  function automatic logic [31:0] val(input logic [7:0] b, input int w, input logic [7:0] s);
    return {8'h00, b, 8'(w), s};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic [3:0] m, input logic [7:0] s);
    @(negedge clk);
    st_valid = 1'b1; st_blk = b; st_mask = m;
    for (int w = 0; w < WORDS; w++) st_line[w*32 +: 32] = val(b, w, s);
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic look(input string tag, input logic [7:0] b, input int w,
                      input logic exp_hit, input logic [31:0] exp_d);
    int cyc;
    @(negedge clk);
    rd_valid = 1'b1; rd_blk = b; rd_word = 2'(w); cyc = 0;
    do begin @(negedge clk); cyc++; end while (!rd_ack && cyc < 20);
    chk({tag, " ack latency"}, 64'(cyc), 64'd1);
    chk({tag, " hit"}, 64'(rd_hit), 64'(exp_hit));
    if (exp_hit) chk({tag, " data"}, 64'(rd_data), 64'(exp_d));
    rd_valid = 1'b0;
  endtask

  // Called at a negedge: compare the offered entry, then take it
  task automatic take(input string tag, input logic [7:0] b, input logic [3:0] m,
                      output logic [127:0] line);
    chk({tag, " mem_valid"}, 64'(mem_valid), 64'd1);
    chk({tag, " mem_blk"}, 64'(mem_blk), 64'(b));
    chk({tag, " mem_mask"}, 64'(mem_mask), 64'(m));
    line = mem_line;
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] ln;
    logic [3:0] ms [4];
    logic [7:0] bs [4];

    repeat (3) @(negedge clk);
    // R1
    chk("R1 mem_valid", 64'(mem_valid), 64'd0);
    chk("R1 rd_ack", 64'(rd_ack), 64'd0);
    chk("R1 st_ready", 64'(st_ready), 64'd1);
    rst = 1'b0;

    // R2: single posted word
    put(8'd5, 4'b0001, 8'd1);
    chk("R2 mem_valid", 64'(mem_valid), 64'd1);
    chk("R2 mem_blk", 64'(mem_blk), 64'd5);
    chk("R2 mem_mask", 64'(mem_mask), 64'b0001);
    chk("R2 word0", 64'(mem_line[31:0]), 64'(val(8'd5, 0, 8'd1)));

    // R4: same block as the head -> new entry; R3: later stores merge there
    put(8'd5, 4'b0010, 8'd2);
    put(8'd5, 4'b0100, 8'd3);
    put(8'd5, 4'b0010, 8'd4);
    chk("R4 head mask unchanged", 64'(mem_mask), 64'b0001);

    // R7 newest copy, R8 unbuffered block
    look("R7 w0 from head", 8'd5, 0, 1'b1, val(8'd5, 0, 8'd1));
    look("R7 w1 overwritten", 8'd5, 1, 1'b1, val(8'd5, 1, 8'd4));
    look("R7 w2 merged", 8'd5, 2, 1'b1, val(8'd5, 2, 8'd3));
    look("R8 other block", 8'd9, 0, 1'b0, 32'd0);

    // R9: missing word waits for both entries of block 5 to drain
    @(negedge clk);
    rd_valid = 1'b1; rd_blk = 8'd5; rd_word = 2'd3;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 held while buffered", 64'(rd_ack), 64'd0);
    end
    chk("R4 head blk", 64'(mem_blk), 64'd5);
    chk("R4 head mask", 64'(mem_mask), 64'b0001);
    mem_ready = 1'b1;
    @(negedge clk);
    chk("R3 merged mask", 64'(mem_mask), 64'b0110);
    chk("R3 merged w1", 64'(mem_line[63:32]), 64'(val(8'd5, 1, 8'd4)));
    chk("R3 merged w2", 64'(mem_line[95:64]), 64'(val(8'd5, 2, 8'd3)));
    chk("R9 held during drain", 64'(rd_ack), 64'd0);
    @(negedge clk);
    mem_ready = 1'b0;
    chk("R5 empty after two drains", 64'(mem_valid), 64'd0);
    chk("R9 held at last drain edge", 64'(rd_ack), 64'd0);
    @(negedge clk);
    chk("R9 ack after drain", 64'(rd_ack), 64'd1);
    chk("R9 miss after drain", 64'(rd_hit), 64'd0);
    rd_valid = 1'b0;

    // R6: full buffer
    for (int b = 1; b <= 4; b++) put(8'(b), 4'b0001, 8'(b));
    @(negedge clk);
    st_blk = 8'd7; #1;
    chk("R6 full no match stalls", 64'(st_ready), 64'd0);
    st_blk = 8'd1; #1;
    chk("R6 full head-only match stalls", 64'(st_ready), 64'd0);
    st_blk = 8'd3; #1;
    chk("R6 full younger match ready", 64'(st_ready), 64'd1);
    put(8'd3, 4'b1000, 8'd9);
    chk("R5 hold blk", 64'(mem_blk), 64'd1);
    @(negedge clk);
    chk("R5 hold blk later", 64'(mem_blk), 64'd1);
    bs[0] = 8'd1; bs[1] = 8'd2; bs[2] = 8'd3; bs[3] = 8'd4;
    ms[0] = 4'b0001; ms[1] = 4'b0001; ms[2] = 4'b1001; ms[3] = 4'b0001;
    for (int k = 0; k < 4; k++) begin
      take("R5 order", bs[k], ms[k], ln);
      chk("R5 word0", 64'(ln[31:0]), 64'(val(bs[k], 0, bs[k])));
      if (k == 2) chk("R6 merged while full", 64'(ln[127:96]), 64'(val(8'd3, 3, 8'd9)));
    end

    // R10: whole evicted block, then a word to the same block
    put(8'h20, 4'b1111, 8'd5);
    for (int w = 0; w < 4; w++) look("R10 full block read", 8'h20, w, 1'b1, val(8'h20, w, 8'd5));
    put(8'h20, 4'b0100, 8'd6);
    look("R7 newer word", 8'h20, 2, 1'b1, val(8'h20, 2, 8'd6));
    look("R7 older word", 8'h20, 1, 1'b1, val(8'h20, 1, 8'd5));
    @(negedge clk);
    take("R10 drain", 8'h20, 4'b1111, ln);
    for (int w = 0; w < 4; w++) chk("R10 word", 64'(ln[w*32 +: 32]), 64'(val(8'h20, w, 8'd5)));
    take("R4 second entry", 8'h20, 4'b0100, ln);
    chk("R4 second entry word", 64'(ln[95:64]), 64'(val(8'h20, 2, 8'd6)));

    // Sweep of every nonzero mask
    for (int m = 1; m < 16; m++) begin
      put(8'(8'h40 + m), 4'(m), 8'(m));
      for (int w = 0; w < 4; w++)
        if (m[w]) look("R7 sweep", 8'(8'h40 + m), w, 1'b1, val(8'(8'h40 + m), w, 8'(m)));
      @(negedge clk);
      take("R2 sweep", 8'(8'h40 + m), 4'(m), ln);
      for (int w = 0; w < 4; w++)
        if (m[w]) chk("R2 sweep word", 64'(ln[w*32 +: 32]), 64'(val(8'(8'h40 + m), w, 8'(m))));
      look("R8 after drain", 8'(8'h40 + m), 0, 1'b0, 32'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule